// File: doc/BRIEF.md
# Global-History Branch Direction Predictor with Confidence

This block predicts the direction of conditional branches. A single global history register records the most recent resolved outcomes. It is combined with a slice of the branch address to select one entry in a table of 2-bit saturating counters. The upper bit of the selected counter gives the taken prediction.

A compile-time parameter selects how the address slice and the history are combined:

- **Concatenation:** the two are joined side by side, giving a table of 2^(address bits + history bits) entries.
- **XOR:** the two are combined by XOR, giving a table of 2^max(address bits, history bits) entries.

A second array shares the same index. Each of its entries is a short shift register that records whether recent predictions at that entry were right or wrong. When enough of those recorded predictions were right, the block raises a high-confidence flag beside the prediction. The fetch stage can use this flag to decide how far to trust the prediction.

The lookup port is purely combinational from the supplied address bits. The caller slices off the instruction alignment bits and presents the address slice. The update port reports one resolved branch per cycle:

- the address slice of the branch;
- its actual direction;
- whether the earlier prediction for it was correct.

An update changes state only at the following clock edge.

Top module: `bp_dir_pred`

## Requirements
- R1: While rst_ni is low, every counter holds 1 (weakly not-taken), and the history and every confidence register hold zero. As a result, every lookup returns pred_taken_o = 0 and pred_conf_o = 1 with the default parameters.
- R2: pred_taken_o equals bit 1 of the counter selected by the lookup index. Counter values 2 and 3 predict taken; values 0 and 1 predict not-taken.
- R3: On an update, the counter at the update index increments if upd_taken_i is 1 and decrements if it is 0. The counter holds at 3 when incrementing and at 0 when decrementing.
- R4: On an update, the history shifts left by one and upd_taken_i enters at bit 0. The oldest bit is dropped.
- R5: With HASH_XOR = 0, the index is {address slice, history}, with the address in the upper bits.
- R6: With HASH_XOR = 1, the index is the address slice XOR the history. Both are zero-extended to the wider of the two widths.
- R7: On an update, the confidence register at the update index shifts left by one. A 0 enters at bit 0 if upd_correct_i is 1, and a 1 enters if upd_correct_i is 0.
- R8: pred_conf_o is 1 exactly when the number of zero bits in the confidence register selected by the lookup index is at least CONF_THRESH.
- R9: Both the lookup index and the update index use the history as it stands before the current cycle's update. A lookup in the same cycle as an update sees the state from before that update; the new state is visible from the next clock edge on.
- R10: While upd_valid_i is 0, the history, the counters and the confidence registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_pc_i | input | ADDR_BITS | Address slice of the branch being predicted |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | ADDR_BITS | Address slice of the resolved branch |
| upd_taken_i | input | 1 | Actual direction of the resolved branch |
| upd_correct_i | input | 1 | The earlier prediction for this branch was correct |
| pred_taken_o | output | 1 | Predicted direction for lkp_pc_i |
| pred_conf_o | output | 1 | High-confidence flag for the prediction |

## Verification
A lookup and an update can fall in the same cycle, including the case where both select the same table entry. The bench provokes this in two ways:

- It drives lookup and update with the same address slice in the same cycle, so the lookup and the counter write select the same entry.
- In random phases it draws both addresses from a small set, so such collisions recur.

The combinational outputs are judged in that same cycle against a bench model that still holds the state from before the update. The model applies the update only after the clock edge. Two instances, one per index mode, receive the same stimulus, so the effect of a colliding write is checked under both hashing schemes.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'd1;  // weakly not-taken

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int HIST_BITS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 taken_i,
  output logic [HIST_BITS-1:0] ghr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ghr_o <= '0;
    else if (shift_i) ghr_o <= {ghr_o[HIST_BITS-2:0], taken_i};
  end
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ADDR_BITS = 4,
  parameter int HIST_BITS = 6,
  parameter bit HASH_XOR  = 1'b0,
  parameter int IDX_W     = 10
) (
  input  logic [ADDR_BITS-1:0] pc_i,
  input  logic [HIST_BITS-1:0] ghr_i,
  output logic [IDX_W-1:0]     idx_o
);
  if (HASH_XOR) begin : g_xor
    logic [IDX_W-1:0] pc_ext, ghr_ext;
    assign pc_ext  = IDX_W'(pc_i);
    assign ghr_ext = IDX_W'(ghr_i);
    assign idx_o   = pc_ext ^ ghr_ext;
  end else begin : g_cat
    assign idx_o = {pc_i, ghr_i};
  end
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  output ctr_t             wr_old_o,
  output ctr_t             wr_new_o
);
  ctr_t tbl_q [ENTRIES];

  assign rd_ctr_o = tbl_q[rd_idx_i];
  assign wr_old_o = tbl_q[wr_idx_i];
  assign wr_new_o = ctr_step(wr_old_o, wr_taken_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= wr_new_o;
    end
  end
endmodule

// File: rtl/bp_conf_table.sv
module bp_conf_table #(
  parameter int IDX_W       = 10,
  parameter int ENTRIES     = 1 << IDX_W,
  parameter int CONF_BITS   = 4,
  parameter int CONF_THRESH = 3,
  localparam int CNT_W      = $clog2(CONF_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [CONF_BITS-1:0] rd_conf_o,
  output logic                 conf_high_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic                 wr_miss_i
);
  logic [CONF_BITS-1:0] tbl_q [ENTRIES];
  logic [CNT_W-1:0]     zeros;

  assign rd_conf_o = tbl_q[rd_idx_i];

  always_comb begin
    zeros = '0;
    for (int b = 0; b < CONF_BITS; b++) zeros = zeros + CNT_W'(!rd_conf_o[b]);
  end

  assign conf_high_o = (zeros >= CNT_W'(CONF_THRESH));

  // 0 = correct, 1 = mispredicted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= {tbl_q[wr_idx_i][CONF_BITS-2:0], wr_miss_i};
    end
  end
endmodule

// File: rtl/bp_dir_pred.sv
module bp_dir_pred
  import bp_pkg::*;
#(
  parameter int ADDR_BITS   = 4,
  parameter int HIST_BITS   = 6,
  parameter bit HASH_XOR    = 1'b0,
  parameter int CONF_BITS   = 4,
  parameter int CONF_THRESH = 3,
  localparam int MAX_W      = (ADDR_BITS > HIST_BITS) ? ADDR_BITS : HIST_BITS,
  localparam int IDX_W      = HASH_XOR ? MAX_W : ADDR_BITS + HIST_BITS,
  localparam int ENTRIES    = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_BITS-1:0] lkp_pc_i,
  input  logic                 upd_valid_i,
  input  logic [ADDR_BITS-1:0] upd_pc_i,
  input  logic                 upd_taken_i,
  input  logic                 upd_correct_i,
  output logic                 pred_taken_o,
  output logic                 pred_conf_o
);
  logic [HIST_BITS-1:0] ghr_q;
  logic [IDX_W-1:0]     lkp_idx, upd_idx;
  ctr_t                 lkp_ctr, upd_ctr_old, upd_ctr_new;
  logic [CONF_BITS-1:0] lkp_conf;

  bp_ghr #(.HIST_BITS(HIST_BITS)) i_ghr (
    .clk_i, .rst_ni, .shift_i(upd_valid_i), .taken_i(upd_taken_i), .ghr_o(ghr_q)
  );

  bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS), .HASH_XOR(HASH_XOR), .IDX_W(IDX_W))
    i_lkp_idx (.pc_i(lkp_pc_i), .ghr_i(ghr_q), .idx_o(lkp_idx));

  bp_index #(.ADDR_BITS(ADDR_BITS), .HIST_BITS(HIST_BITS), .HASH_XOR(HASH_XOR), .IDX_W(IDX_W))
    i_upd_idx (.pc_i(upd_pc_i), .ghr_i(ghr_q), .idx_o(upd_idx));

  bp_ctr_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES)) i_ctr (
    .clk_i, .rst_ni,
    .rd_idx_i(lkp_idx), .rd_ctr_o(lkp_ctr),
    .wr_en_i(upd_valid_i), .wr_idx_i(upd_idx), .wr_taken_i(upd_taken_i),
    .wr_old_o(upd_ctr_old), .wr_new_o(upd_ctr_new)
  );

  bp_conf_table #(.IDX_W(IDX_W), .ENTRIES(ENTRIES), .CONF_BITS(CONF_BITS),
                  .CONF_THRESH(CONF_THRESH)) i_conf (
    .clk_i, .rst_ni,
    .rd_idx_i(lkp_idx), .rd_conf_o(lkp_conf), .conf_high_o(pred_conf_o),
    .wr_en_i(upd_valid_i), .wr_idx_i(upd_idx), .wr_miss_i(!upd_correct_i)
  );

  assign pred_taken_o = lkp_ctr[1];
endmodule

// File: rtl/bp_dir_pred_chk.sv
module bp_dir_pred_chk #(
  parameter int HIST_BITS = 6,
  parameter int CONF_BITS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 upd_valid_i,
  input logic                 upd_taken_i,
  input logic [HIST_BITS-1:0] ghr_q,
  input logic [1:0]           lkp_ctr,
  input logic                 pred_taken_o,
  input logic [CONF_BITS-1:0] lkp_conf,
  input logic                 pred_conf_o,
  input logic [1:0]           upd_ctr_old,
  input logic [1:0]           upd_ctr_new
);
  // R4
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghr_q == {$past(ghr_q[HIST_BITS-2:0]), $past(upd_taken_i)});

  // R10
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q));

  // R3
  ctr_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |-> upd_ctr_new >= upd_ctr_old);

  // R3
  ctr_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |-> upd_ctr_new <= upd_ctr_old);

  // R2
  pred_nt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_ctr == 2'd0) |-> !pred_taken_o);

  // R8
  conf_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(lkp_conf) == 0) |-> pred_conf_o);
endmodule

bind bp_dir_pred bp_dir_pred_chk #(.HIST_BITS(HIST_BITS), .CONF_BITS(CONF_BITS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
  .ghr_q(ghr_q), .lkp_ctr(lkp_ctr), .pred_taken_o(pred_taken_o), .lkp_conf(lkp_conf),
  .pred_conf_o(pred_conf_o), .upd_ctr_old(upd_ctr_old), .upd_ctr_new(upd_ctr_new)
);

// File: tb/test_bp_dir_pred.sv
`timescale 1ns/1ps
module test_bp_dir_pred;
  localparam int A  = 4;
  localparam int H  = 6;
  localparam int CB = 4;
  localparam int TH = 3;
  localparam int N  = 1 << (A + H);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [A-1:0] lkp_pc = '0, upd_pc = '0;
  logic upd_valid = 1'b0, upd_taken = 1'b0, upd_correct = 1'b0;
  logic pred [2];
  logic conf [2];

  int checks = 0;
  int fails  = 0;

  logic [1:0]    ctr_m  [2][N];
  logic [CB-1:0] conf_m [2][N];
  logic [H-1:0]  ghr_m;

  always #4 clk = ~clk;

  bp_dir_pred #(.ADDR_BITS(A), .HIST_BITS(H), .HASH_XOR(1'b0), .CONF_BITS(CB),
                .CONF_THRESH(TH)) i_bp_dir_pred (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc), .upd_valid_i(upd_valid),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_correct_i(upd_correct),
    .pred_taken_o(pred[0]), .pred_conf_o(conf[0]));

  bp_dir_pred #(.ADDR_BITS(A), .HIST_BITS(H), .HASH_XOR(1'b1), .CONF_BITS(CB),
                .CONF_THRESH(TH)) i_bp_dir_pred_xor (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_pc_i(lkp_pc), .upd_valid_i(upd_valid),
    .upd_pc_i(upd_pc), .upd_taken_i(upd_taken), .upd_correct_i(upd_correct),
    .pred_taken_o(pred[1]), .pred_conf_o(conf[1]));

  // R5 concatenated, R6 xor with zero extension
  function automatic int idx_f(int mode, logic [A-1:0] pc, logic [H-1:0] h);
    if (mode == 1) return int'({{(H-A){1'b0}}, pc} ^ h);
    return int'({pc, h});
  endfunction

  function automatic int zeros_f(logic [CB-1:0] v);
    int z = 0;
    for (int b = 0; b < CB; b++) if (!v[b]) z++;
    return z;
  endfunction

  task automatic check(string tag, int m, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst=%s %s actual=%0b expected=%0b", tag,
               (m == 0) ? "R5" : "R6", (m == 0) ? "cat" : "xor", what, act, exp);
    end
  endtask

  task automatic check_outputs(string tag, logic [A-1:0] pc);
    for (int m = 0; m < 2; m++) begin
      int i = idx_f(m, pc, ghr_m);
      check(tag, m, pred[m], ctr_m[m][i][1], "pred_taken R2");
      check(tag, m, conf[m], zeros_f(conf_m[m][i]) >= TH, "pred_conf R8");
    end
  endtask

  // drive at negedge, check same-cycle lookup (pre-update state, R9), model update after edge
  task automatic step(string tag, logic [A-1:0] lpc, logic uv, logic [A-1:0] upc,
                      logic ut, logic uc);
    lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_correct = uc;
    #1;
    check_outputs(tag, lpc);
    @(posedge clk);
    if (uv) begin
      for (int m = 0; m < 2; m++) begin
        int i = idx_f(m, upc, ghr_m);
        // R3 saturating counter
        if (ut) ctr_m[m][i] = (ctr_m[m][i] == 2'd3) ? 2'd3 : ctr_m[m][i] + 2'd1;
        else    ctr_m[m][i] = (ctr_m[m][i] == 2'd0) ? 2'd0 : ctr_m[m][i] - 2'd1;
        // R7 0 = correct
        conf_m[m][i] = {conf_m[m][i][CB-2:0], !uc};
      end
      ghr_m = {ghr_m[H-2:0], ut};  // R4
    end
    @(negedge clk);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_test();
  end

  initial begin
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < N; i++) begin
        ctr_m[m][i] = 2'd1;
        conf_m[m][i] = '0;
      end
    ghr_m = '0;

    // R1 reset state seen through lookups
    #20;
    for (int p = 0; p < 16; p += 5) begin
      lkp_pc = A'(p);
      #1;
      for (int m = 0; m < 2; m++) begin
        check("R1", m, pred[m], 1'b0, "reset pred_taken");
        check("R1", m, conf[m], 1'b1, "reset pred_conf");
      end
    end
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 drive history to all ones and saturate counter at 3
    for (int n = 0; n < 12; n++) step("R3", 4'h5, 1'b1, 4'h5, 1'b1, 1'b1);
    check_outputs("R2", 4'h5);
    // R3 drive history to zero and saturate at 0
    for (int n = 0; n < 12; n++) step("R3", 4'h3, 1'b1, 4'h3, 1'b0, 1'b1);

    // R7 R8 mispredictions at fixed index lower confidence
    for (int n = 0; n < 3; n++) step("R7", 4'h3, 1'b1, 4'h3, 1'b0, 1'b0);
    check_outputs("R8", 4'h3);
    step("R8", 4'h3, 1'b1, 4'h3, 1'b0, 1'b1);
    check_outputs("R8", 4'h3);

    // R9 same-cycle lookup and update on the same entry
    for (int n = 0; n < 8; n++) step("R9", 4'h9, 1'b1, 4'h9, n[0], n[1]);

    // R10 no update: inputs wiggle, state must stay
    for (int n = 0; n < 20; n++)
      step("R10", A'($urandom), 1'b0, A'($urandom), 1'($urandom), 1'($urandom));

    // random mix with frequent collisions
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [A-1:0] lp, up;
      up = A'($urandom % 6);
      lp = ($urandom % 3 == 0) ? up : A'($urandom % 6);
      step("R9", lp, ($urandom % 4) != 0, up, 1'($urandom), ($urandom % 3) != 0);
    end

    finish_test();
  end
endmodule